// File: doc/BRIEF.md
# Row-Locality Bus Arbiter

This block arbitrates among several bus masters that share one DRAM memory controller. Each master presents one pending transaction: a valid flag, a target address and a direction bit (read or write). The arbiter grants one master at a time. It orders grants so that consecutive accepted transactions stay on the same DRAM row and in the same direction for as long as it can. This cuts the number of row activations and bus turnarounds the controller has to perform.

The row is a fixed bit field of the address, set by parameters. The arbiter records the row, the direction and the master index of the last accepted grant. While that master keeps asking for the same row in the same direction, it keeps the grant, up to a run limit. When the run ends, any other master whose request matches the recorded row and direction is preferred. Among several such masters, and among all requesters when none of them matches, the choice is round-robin starting after the last granted master. The grant is decided combinationally from the inputs and the registered history. A grant counts as accepted when `gnt_valid` and `gnt_ready` are both high.

Top module: `rla_arbiter`

## Requirements
- R1: The grant vector `gnt` has at most one bit set and only for a master whose `req_valid` bit is high. `gnt_valid` is high exactly when some request is valid, and `gnt_idx` is the index of the set bit.
- R2: When the last granted master requests again with the same row and the same direction as the last accepted grant, and its run holds fewer than MAX_RUN grants, it is granted again.
- R3: If the last granted master's new request targets a different row, its run ends and the grant goes to another master by the handoff rules.
- R4: If the last granted master's new request has the other direction (bit value 1 = write, 0 = read), its run ends in the same way, even on the same row.
- R5: At a handoff, a requester whose row and direction both equal those of the last accepted grant wins over every requester that does not match.
- R6: When several requesters match at a handoff, the winner is the first match in index order starting from the last granted index plus one, wrapping modulo the master count.
- R7: When no requester matches at a handoff, the winner is the first valid requester in that same circular order, with the last granted master considered last.
- R8: A run holds at most MAX_RUN consecutive grants. After that, a matching or other valid requester is granted instead, and the capped master is granted again only if it is the sole requester, which starts a new run.
- R9: After reset, no row or direction is recorded, so nothing matches. The first grant goes to the lowest-indexed valid requester, because the last-index register resets to the highest index.
- R10: The recorded row, direction, index and run length change only on an accepted grant. While `gnt_ready` is low and the requests are unchanged, the grant stays the same.
- R11: Only address bits [ROW_LO+ROW_W-1:ROW_LO] take part in matching. Differences in any other address bit do not change the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Per-master request pending |
| req_addr | input | N*ADDR_W | Per-master target address; master i at bits [i*ADDR_W +: ADDR_W] |
| req_write | input | N | Per-master direction, 1 = write, 0 = read |
| gnt_ready | input | 1 | Controller accepts the current grant |
| gnt | output | N | One-hot grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_idx | output | $clog2(N) | Index of the granted master |

## Verification
The assertions assume that the masters hold their requests steady between clock edges and that `gnt_ready` is a plain level which may change in any cycle, including while a grant is not taken. The continuation and locality properties read the recorded history and the current request fields at the same edge, so they rely on addresses and direction bits being known whenever the matching valid bit is high. The stimulus changes inputs only at the falling clock edge, keeps every address field defined, and draws rows from a small set so that matches, mismatches and capped runs all occur often.

// File: rtl/rla_pkg.sv
package rla_pkg;

    // How the current grant was chosen
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CONT  = 2'd1,
        SEL_MATCH = 2'd2,
        SEL_RR    = 2'd3
    } sel_e;

    function automatic logic sel_grants(input sel_e k);
        return k != SEL_NONE;
    endfunction

    function automatic logic sel_extends_run(input sel_e k);
        return k == SEL_CONT;
    endfunction

endpackage

// File: rtl/rla_match.sv
module rla_match #(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int ROW_LO = 13,
    parameter int ROW_W  = 14
) (
    input  logic [N-1:0]        req_valid,
    input  logic [N*ADDR_W-1:0] req_addr,
    input  logic [N-1:0]        req_write,
    input  logic                hist_valid,
    input  logic [ROW_W-1:0]    last_row,
    input  logic                last_wr,
    output logic [N*ROW_W-1:0]  req_row,
    output logic [N-1:0]        match
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [ROW_W-1:0] row_i;
        assign row_i = req_addr[i*ADDR_W + ROW_LO +: ROW_W];
        assign req_row[i*ROW_W +: ROW_W] = row_i;
        assign match[i] = req_valid[i] & hist_valid &
                          (row_i == last_row) & (req_write[i] == last_wr);
    end

endmodule

// File: rtl/rla_rr_pick.sv
module rla_rr_pick #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] pick_idx
);

    // Scan last+1, last+2, ... last (wrapping); first candidate wins
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_idx) + k) % N;
            if (!found && cand[j[IDX_W-1:0]]) begin
                found    = 1'b1;
                pick_idx = j[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rla_hist.sv
module rla_hist #(
    parameter int N       = 4,
    parameter int ROW_W   = 14,
    parameter int MAX_RUN = 8,
    localparam int IDX_W  = $clog2(N),
    localparam int RUN_W  = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             extend,
    input  logic [IDX_W-1:0] g_idx,
    input  logic [ROW_W-1:0] g_row,
    input  logic             g_wr,
    output logic             hist_valid,
    output logic [ROW_W-1:0] last_row,
    output logic             last_wr,
    output logic [IDX_W-1:0] last_idx,
    output logic [RUN_W-1:0] run_cnt
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_valid <= 1'b0;
            last_row   <= '0;
            last_wr    <= 1'b0;
            last_idx   <= IDX_TOP;
            run_cnt    <= '0;
        end else if (acc) begin
            hist_valid <= 1'b1;
            last_row   <= g_row;
            last_wr    <= g_wr;
            last_idx   <= g_idx;
            run_cnt    <= extend ? run_cnt + RUN_W'(1) : RUN_W'(1);
        end
    end

endmodule

// File: rtl/rla_arbiter.sv
module rla_arbiter #(
    parameter int N       = 4,
    parameter int ADDR_W  = 32,
    parameter int ROW_LO  = 13,
    parameter int ROW_W   = 14,
    parameter int MAX_RUN = 8,
    localparam int IDX_W  = $clog2(N),
    localparam int RUN_W  = $clog2(MAX_RUN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        req_valid,
    input  logic [N*ADDR_W-1:0] req_addr,
    input  logic [N-1:0]        req_write,
    input  logic                gnt_ready,
    output logic [N-1:0]        gnt,
    output logic                gnt_valid,
    output logic [IDX_W-1:0]    gnt_idx
);
    import rla_pkg::*;

    logic             hist_valid;
    logic [ROW_W-1:0] last_row;
    logic             last_wr;
    logic [IDX_W-1:0] last_idx;
    logic [RUN_W-1:0] run_cnt;

    logic [N*ROW_W-1:0] req_row;
    logic [N-1:0]       match;
    logic [N-1:0]       match_others;
    logic               m_found, a_found;
    logic [IDX_W-1:0]   m_idx, a_idx;
    logic               cont;
    sel_e               sel;
    logic               unused_addr;

    // Bits outside the row field only reach this reduction
    assign unused_addr = ^req_addr;

    rla_match #(.N(N), .ADDR_W(ADDR_W), .ROW_LO(ROW_LO), .ROW_W(ROW_W)) match_i (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .hist_valid(hist_valid),
        .last_row  (last_row),
        .last_wr   (last_wr),
        .req_row   (req_row),
        .match     (match)
    );

    // A matching last master that did not continue has hit the run cap
    always_comb begin
        match_others = match;
        match_others[last_idx] = 1'b0;
    end

    rla_rr_pick #(.N(N)) pick_match_i (
        .cand    (match_others),
        .last_idx(last_idx),
        .found   (m_found),
        .pick_idx(m_idx)
    );

    rla_rr_pick #(.N(N)) pick_all_i (
        .cand    (req_valid),
        .last_idx(last_idx),
        .found   (a_found),
        .pick_idx(a_idx)
    );

    assign cont = match[last_idx] && (run_cnt < RUN_W'(MAX_RUN));

    always_comb begin
        if (cont)         sel = SEL_CONT;
        else if (m_found) sel = SEL_MATCH;
        else if (a_found) sel = SEL_RR;
        else              sel = SEL_NONE;
    end

    always_comb begin
        unique case (sel)
            SEL_CONT:  gnt_idx = last_idx;
            SEL_MATCH: gnt_idx = m_idx;
            SEL_RR:    gnt_idx = a_idx;
            default:   gnt_idx = '0;
        endcase
        gnt_valid = sel_grants(sel);
        gnt = '0;
        if (gnt_valid) gnt[gnt_idx] = 1'b1;
    end

    rla_hist #(.N(N), .ROW_W(ROW_W), .MAX_RUN(MAX_RUN)) hist_i (
        .clk       (clk),
        .rst       (rst),
        .acc       (gnt_valid & gnt_ready),
        .extend    (sel_extends_run(sel)),
        .g_idx     (gnt_idx),
        .g_row     (req_row[gnt_idx*ROW_W +: ROW_W]),
        .g_wr      (req_write[gnt_idx]),
        .hist_valid(hist_valid),
        .last_row  (last_row),
        .last_wr   (last_wr),
        .last_idx  (last_idx),
        .run_cnt   (run_cnt)
    );

endmodule

// File: rtl/rla_arbiter_chk.sv
module rla_arbiter_chk #(
    parameter int N       = 4,
    parameter int ADDR_W  = 32,
    parameter int ROW_LO  = 13,
    parameter int ROW_W   = 14,
    parameter int MAX_RUN = 8,
    localparam int IDX_W  = $clog2(N),
    localparam int RUN_W  = $clog2(MAX_RUN + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        req_valid,
    input logic [N*ADDR_W-1:0] req_addr,
    input logic [N-1:0]        req_write,
    input logic                gnt_ready,
    input logic [N-1:0]        gnt,
    input logic                gnt_valid,
    input logic [IDX_W-1:0]    gnt_idx,
    input logic                hist_valid,
    input logic [ROW_W-1:0]    last_row,
    input logic                last_wr,
    input logic [IDX_W-1:0]    last_idx,
    input logic [RUN_W-1:0]    run_cnt
);

    logic             can_continue;
    logic             other_match;
    logic             granted_match;
    logic             unused_chk;

    assign unused_chk = ^req_addr;

    always_comb begin
        can_continue  = 1'b0;
        other_match   = 1'b0;
        granted_match = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic hit;
            hit = hist_valid && req_valid[i] && (req_write[i] == last_wr) &&
                  (req_addr[i*ADDR_W + ROW_LO +: ROW_W] == last_row);
            if (i == int'(last_idx)) begin
                if (hit && (int'(run_cnt) < MAX_RUN)) can_continue = 1'b1;
            end else if (hit) begin
                other_match = 1'b1;
            end
            if (hit && gnt[i]) granted_match = 1'b1;
        end
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ($onehot(gnt) && ((gnt & ~req_valid) == '0) && gnt[gnt_idx]));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid == '0) |-> (!gnt_valid && gnt == '0));

    assert_keep_run_R2: assert property (@(posedge clk) disable iff (rst)
        can_continue |-> gnt[last_idx]);

    assert_local_first_R5: assert property (@(posedge clk) disable iff (rst)
        (!can_continue && other_match) |-> granted_match);

    assert_run_cap_R8: assert property (@(posedge clk) disable iff (rst)
        int'(run_cnt) <= MAX_RUN);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!hist_valid && run_cnt == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(gnt_valid && gnt_ready) |=> $stable({hist_valid, last_row, last_wr, last_idx, run_cnt}));

endmodule

bind rla_arbiter rla_arbiter_chk #(
    .N(N), .ADDR_W(ADDR_W), .ROW_LO(ROW_LO), .ROW_W(ROW_W), .MAX_RUN(MAX_RUN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .gnt_ready (gnt_ready),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .hist_valid(hist_valid),
    .last_row  (last_row),
    .last_wr   (last_wr),
    .last_idx  (last_idx),
    .run_cnt   (run_cnt)
);

// File: tb/rla_arbiter_tb_top.sv
module rla_arbiter_tb_top;

    localparam int N      = 4;
    localparam int ADDR_W = 12;
    localparam int ROW_LO = 4;
    localparam int ROW_W  = 3;
    localparam int MAXR   = 3;
    localparam int IDX_W  = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        req_valid;
    logic [N*ADDR_W-1:0] req_addr;
    logic [N-1:0]        req_write;
    logic                gnt_ready = 1'b0;
    logic [N-1:0]        gnt;
    logic                gnt_valid;
    logic [IDX_W-1:0]    gnt_idx;

    logic [ROW_W-1:0]    tb_row [N];
    logic [ADDR_W-ROW_W-1:0] tb_rest [N];
    logic [N-1:0]        tb_v = '0;
    logic [N-1:0]        tb_w = '0;

    int vectors = 0;
    int errors  = 0;

    // Bench model of the history
    bit             m_hv;
    int             m_last;
    logic [ROW_W-1:0] m_row;
    bit             m_wr;
    int             m_run;

    always #5 clk = ~clk;

    always_comb begin
        req_valid = tb_v;
        req_write = tb_w;
        for (int i = 0; i < N; i++)
            req_addr[i*ADDR_W +: ADDR_W] = {tb_rest[i][ADDR_W-ROW_W-1:ROW_LO],
                                            tb_row[i], tb_rest[i][ROW_LO-1:0]};
    end

    rla_arbiter #(.N(N), .ADDR_W(ADDR_W), .ROW_LO(ROW_LO), .ROW_W(ROW_W), .MAX_RUN(MAXR)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .gnt_ready(gnt_ready), .gnt(gnt),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    task automatic model_reset();
        m_hv = 1'b0; m_last = N - 1; m_row = '0; m_wr = 1'b0; m_run = 0;
    endtask

    task automatic setm(input int i, input bit v, input bit w,
                        input logic [ROW_W-1:0] r, input logic [ADDR_W-ROW_W-1:0] rest);
        tb_v[i] = v; tb_w[i] = w; tb_row[i] = r; tb_rest[i] = rest;
    endtask

    function automatic bit hits(input int i);
        return m_hv && tb_v[i] && tb_row[i] == m_row && tb_w[i] == m_wr;
    endfunction

    // Called just after the falling edge once inputs are set
    task automatic chk(input bit rdy, input string dtag);
        int    e;
        int    nm;
        bit    cont;
        string tag;
        logic [N-1:0] e_gnt;
        gnt_ready = rdy;
        #1;
        e = -1; cont = 1'b0; nm = 0;
        if (hits(m_last) && m_run < MAXR) begin
            e = m_last; cont = 1'b1; tag = "R2";
        end else begin
            if (!m_hv)                          tag = "R9";
            else if (tb_v[m_last] && tb_row[m_last] != m_row) tag = "R3";
            else if (tb_v[m_last] && tb_w[m_last] != m_wr)    tag = "R4";
            else if (tb_v[m_last])              tag = "R8";
            else                                tag = "R7";
            for (int k = 1; k < N; k++) begin
                int i;
                i = (m_last + k) % N;
                if (hits(i)) begin
                    nm++;
                    if (e < 0) e = i;
                end
            end
            if (nm == 1 && tag == "R7") tag = "R5";
            if (nm > 1) tag = "R6";
            if (e < 0) begin
                for (int k = 1; k <= N; k++) begin
                    int i;
                    i = (m_last + k) % N;
                    if (e < 0 && tb_v[i]) e = i;
                end
            end
            if (e < 0) tag = "R1";
        end
        if (dtag != "") tag = dtag;
        e_gnt = '0;
        if (e >= 0) e_gnt[e] = 1'b1;
        vectors++;
        if (gnt !== e_gnt || gnt_valid !== (e >= 0) ||
            (e >= 0 && gnt_idx !== IDX_W'(e))) begin
            errors++;
            $display("FAIL %s: gnt=%b valid=%b idx=%0d expected gnt=%b valid=%b idx=%0d",
                     tag, gnt, gnt_valid, gnt_idx, e_gnt, e >= 0, e);
        end
        if (e >= 0 && rdy) begin
            m_run  = cont ? m_run + 1 : 1;
            m_hv   = 1'b1;
            m_last = e;
            m_row  = tb_row[e];
            m_wr   = tb_w[e];
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) setm(i, 1'b0, 1'b0, '0, '0);
        model_reset();
        // Reset state: nothing requested, nothing granted (R1, R9)
        @(negedge clk); chk(1'b1, "R9");
        @(negedge clk); chk(1'b1, "R1");
        rst = 1'b0;
        model_reset();

        // R9: first grant after reset goes to lowest valid index
        @(negedge clk); setm(2, 1, 1, 3'd5, 9'h011); setm(3, 1, 0, 3'd1, 9'h000);
        chk(1'b1, "R9");
        // R2: master 2 continues on row 5 write, master 0 also matches
        @(negedge clk); setm(3, 0, 0, 0, 0); setm(0, 1, 1, 3'd5, 9'h0F0);
        chk(1'b1, "R2");
        @(negedge clk); chk(1'b1, "R2");
        // R8: run capped at three grants, matching master 0 takes over
        @(negedge clk); chk(1'b1, "R8");
        // R11: other address bits differ, same row keeps the run
        @(negedge clk); setm(0, 1, 1, 3'd5, 9'h1AB); chk(1'b1, "R11");
        // R10: ready low, grant and state hold
        @(negedge clk); setm(1, 1, 1, 3'd5, 9'h000); chk(1'b0, "R10");
        @(negedge clk); chk(1'b0, "R10");
        @(negedge clk); chk(1'b1, "R10");
        // R3: master 0 switches row; master 1 matches and wins over master 3
        @(negedge clk); setm(0, 1, 1, 3'd6, 0); setm(3, 1, 0, 3'd5, 0);
        chk(1'b1, "R3");
        // R4: master 1 turns to a read on the same row; master 2 write matches
        @(negedge clk); setm(1, 1, 0, 3'd5, 0); chk(1'b1, "R4");
        // R6: masters 0 and 3 both match row 5 write, round-robin after 2
        @(negedge clk); setm(0, 1, 1, 3'd5, 0); setm(3, 1, 1, 3'd5, 0); setm(2, 0, 0, 0, 0);
        chk(1'b1, "R6");
        // R7: nobody matches, round-robin after 3 picks master 0
        @(negedge clk); setm(0, 1, 0, 3'd2, 0); setm(1, 1, 0, 3'd3, 0); setm(3, 0, 0, 0, 0);
        chk(1'b1, "R7");
        // R8: sole requester past the cap is granted again
        for (int n = 0; n < 5; n++) begin
            @(negedge clk); setm(1, 0, 0, 0, 0); chk(1'b1, "R8");
        end

        // Near-exhaustive sweep over small rows and mixed directions
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                bit v;
                bit w;
                logic [ROW_W-1:0] r;
                v = ($urandom % 5) != 0;
                w = (($urandom % 5) == 0) ? ~tb_w[i] : tb_w[i];
                r = (($urandom % 4) != 0) ? ROW_W'($urandom % 2) : ROW_W'($urandom);
                setm(i, v, w, r, 9'($urandom));
            end
            chk(($urandom % 5) != 0, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule